// File: doc/BRIEF.md
# Motor Speed Lock Detector

This block decides when a brushless motor has settled at a steady speed. Each time an upstream timer finishes measuring the Hall U period, it presents the count (in 50 MHz clock cycles) with a one-cycle valid strobe. The detector applies three tests to that measurement:

- **Minimum speed:** the period must be shorter than a programmable limit.
- **Speed change:** the period-to-period change must be no larger than a power-of-two fraction of the current period.
- **Persistence:** enough consecutive measurements must pass both tests.

Only when all three agree does the registered lock flag rise. Any failed measurement drops the flag at once and restarts the count.

The limit field is in units of 128000 clock cycles (2.56 ms at 50 MHz). The change tolerance is chosen by a 3-bit shift code. The persistence count is an 8-bit revolution value. Pulling the enable input low returns the block to its idle state without a reset.

Top module: `spd_lock_det`

## Requirements
- R1: While `rst_n` or `enable` is low, `lock` is 0 on the next clock, the revolution counter is reloaded, and the stored previous period is forgotten.
- R2: A measurement passes the speed test only if `per_value` < `minspd_lim` × 128000. A field value of 0 never passes. The limit follows a field change one clock later.
- R3: The first measurement after reset or after `enable` rises has no predecessor. It counts as a speed change (a failure), so `lock` is 0 after it.
- R4: The change test passes when |`per_value` − previous period| ≤ `per_value` >> (`chg_shift` + 2). Code 0 selects /4, code 1 selects /8, and so on up to code 7, which selects /512.
- R5: The revolution counter loads `min_revs`. It decrements on each measurement that passes both tests, and `lock` goes to 1 on the clock after the strobe that brings it to zero.
- R6: A measurement that fails either test reloads the counter from `min_revs` and makes `lock` 0 on the clock after its strobe.
- R7: Without a valid strobe, `lock` and the counter hold their values.
- R8: With `min_revs` = 0, the first passing measurement sets `lock`. While `lock` is 1, further passing measurements keep it at 1 with the counter held at zero.
- R9: The previous period is replaced by every strobed measurement, including one that fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Detector enable; low clears the lock state |
| per_valid | input | 1 | One-cycle strobe marking a new period measurement |
| per_value | input | 25 | Measured Hall U period in clock cycles |
| minspd_lim | input | 8 | Longest allowed period, in units of 128000 cycles |
| chg_shift | input | 3 | Change tolerance code k; threshold = period >> (k+2) |
| min_revs | input | 8 | Number of consecutive good measurements required |
| lock | output | 1 | Speed lock flag |

## Verification
Two events can land on the same strobe:

- **Counter reaching zero against a failure.** The revolution counter is one step from zero while the measurement fails the minimum-speed test. The bench provokes this by lowering the limit field just before the deciding strobe. It judges the result by `lock` staying 0 and by the count that follows: after the reload, the full `min_revs` run of good measurements is needed again.
- **Enable falling with a strobe.** The enable is dropped in the same cycle as a strobe. The bench then checks that `lock` clears and that the next strobe after re-enable is treated as having no predecessor.

A behavioural reference model, built from integers, is compared against `lock` on every clock.

// File: rtl/lock_pkg.sv
// Package: lock_pkg
// Shared sizing constants for the speed lock detector. All widths and
// scale factors used by the submodules default to the values here.
package lock_pkg;
    parameter int PER_W      = 25;      // period measurement width
    parameter int FLD_W      = 8;       // minimum-speed field width
    parameter int SHF_W      = 3;       // change-tolerance code width
    parameter int REV_W      = 8;       // revolution counter width
    parameter int TICKS_UNIT = 128000;  // clock cycles per limit count
    parameter int SHIFT_BASE = 2;       // code k selects shift k+SHIFT_BASE

    // Outcome of the checks for one measurement.
    typedef struct packed {
        logic fast;    // period below the minimum-speed limit
        logic steady;  // change within tolerance
    } meas_chk_t;
endpackage

// File: rtl/lock_minspd.sv
// Module: lock_minspd
// Minimum-speed test. The limit (field times a fixed tick count) is
// computed into a register, so the comparison path holds only a
// comparator. Assumes the field is quasi-static: a new field value
// takes effect one clock after it is applied.
module lock_minspd
    import lock_pkg::*;
#(
    parameter int P_PER_W  = PER_W,
    parameter int P_FLD_W  = FLD_W,
    parameter int P_TICKS  = TICKS_UNIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_FLD_W-1:0] lim_field,
    input  logic [P_PER_W-1:0] period,
    output logic               fast
);
    localparam int TICK_W = $clog2(P_TICKS + 1);
    localparam int PROD_W = P_FLD_W + TICK_W;
    localparam int CMP_W  = (P_PER_W > PROD_W) ? P_PER_W : PROD_W;

    logic [PROD_W-1:0] lim_q;

    // Register the scaled limit from the field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else begin
            lim_q <= PROD_W'(lim_field) * PROD_W'(P_TICKS);
        end
    end

    // Pass only when the period is strictly shorter than the limit.
    always_comb begin
        fast = (CMP_W'(period) < CMP_W'(lim_q));
    end

    // A zero limit must never let a measurement through (R2).
    p_zero_limit_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q == '0) |-> !fast);
endmodule

// File: rtl/lock_chg_detect.sv
// Module: lock_chg_detect
// Speed-change test. Keeps the previous strobed period and compares the
// absolute difference with the current period shifted right by a
// selectable amount. Assumes per_valid is a single-cycle strobe. The first
// measurement after enable has no predecessor and is reported unsteady.
module lock_chg_detect
    import lock_pkg::*;
#(
    parameter int P_PER_W  = PER_W,
    parameter int P_SHF_W  = SHF_W,
    parameter int P_SBASE  = SHIFT_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               per_valid,
    input  logic [P_PER_W-1:0] period,
    input  logic [P_SHF_W-1:0] shift_code,
    output logic               steady
);
    localparam int NCODES = 1 << P_SHF_W;

    logic [P_PER_W-1:0] prev_q;
    logic               have_prev_q;
    logic [P_PER_W-1:0] diff;
    logic [P_PER_W-1:0] thr;
    logic [P_PER_W-1:0] thr_opt [NCODES];

    // One fixed-shift threshold candidate per tolerance code.
    for (genvar g = 0; g < NCODES; g++) begin : g_thr
        assign thr_opt[g] = period >> (g + P_SBASE);
    end

    // Select the threshold for the programmed code.
    always_comb begin
        thr = thr_opt[shift_code];
    end

    // Absolute difference between the current and stored periods.
    always_comb begin
        if (period >= prev_q) begin
            diff = period - prev_q;
        end else begin
            diff = prev_q - period;
        end
    end

    // Steady only with a predecessor and a change within tolerance.
    always_comb begin
        steady = have_prev_q && (diff <= thr);
    end

    // Store every strobed period; forget it when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (per_valid) begin
            prev_q      <= period;
            have_prev_q <= 1'b1;
        end
    end

    // The stored period is the last strobed value (R9).
    p_prev_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && per_valid) |=> (prev_q == $past(period)));

    // Without a predecessor the measurement cannot be steady (R3).
    p_no_prev_unsteady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> !steady);
endmodule

// File: rtl/lock_rev_counter.sv
// Module: lock_rev_counter
// Consecutive-good-measurement counter and lock flag. Counts down from
// the programmed revolution value on each fully passing measurement and
// raises the lock when it reaches zero. Any failure reloads and unlocks.
// Assumes min_revs is stable while counting.
module lock_rev_counter
    import lock_pkg::*;
#(
    parameter int P_REV_W = REV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               meas_valid,
    input  meas_chk_t          chk,
    input  logic [P_REV_W-1:0] min_revs,
    output logic               lock
);
    logic [P_REV_W-1:0] cnt_q;
    logic [P_REV_W-1:0] cnt_nxt;
    logic               all_ok;
    logic               lock_q;

    // Both tests must pass for a measurement to count.
    always_comb begin
        all_ok = chk.fast && chk.steady;
    end

    // Decrement, saturating at zero.
    always_comb begin
        if (cnt_q == '0) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q - 1'b1;
        end
    end

    // Counter and lock update per strobed measurement.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q  <= min_revs;
            lock_q <= 1'b0;
        end else if (meas_valid) begin
            if (all_ok) begin
                cnt_q  <= cnt_nxt;
                lock_q <= (cnt_nxt == '0);
            end else begin
                cnt_q  <= min_revs;
                lock_q <= 1'b0;
            end
        end
    end

    assign lock = lock_q;

    // Disabled means unlocked on the next clock (R1).
    p_disable_unlocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !lock);

    // A failed measurement unlocks and reloads (R6).
    p_fail_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && meas_valid && !all_ok) |=> (!lock && cnt_q == $past(min_revs)));

    // No strobe, no change (R7).
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !meas_valid && $past(enable)) |=> ($stable(lock) && $stable(cnt_q)));

    // A rising lock follows a passing measurement (R5).
    p_lock_from_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> ($past(meas_valid) && $past(all_ok)));

    // While locked the counter rests at zero (R8).
    p_locked_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (cnt_q == '0));
endmodule

// File: rtl/spd_lock_det.sv
// Module: spd_lock_det
// Motor speed lock detector top. Feeds each strobed Hall U period to
// the minimum-speed and speed-change tests, then to the revolution
// counter that owns the lock flag. Assumes a 50 MHz clock and a period
// counted in those clocks.
module spd_lock_det
    import lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             per_valid,
    input  logic [PER_W-1:0] per_value,
    input  logic [FLD_W-1:0] minspd_lim,
    input  logic [SHF_W-1:0] chg_shift,
    input  logic [REV_W-1:0] min_revs,
    output logic             lock
);
    meas_chk_t chk;
    logic      fast;
    logic      steady;

    lock_minspd #(
        .P_PER_W (PER_W),
        .P_FLD_W (FLD_W),
        .P_TICKS (TICKS_UNIT)
    ) u_minspd (
        .clk       (clk),
        .rst_n     (rst_n),
        .lim_field (minspd_lim),
        .period    (per_value),
        .fast      (fast)
    );

    lock_chg_detect #(
        .P_PER_W (PER_W),
        .P_SHF_W (SHF_W),
        .P_SBASE (SHIFT_BASE)
    ) u_chg (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .per_valid  (per_valid),
        .period     (per_value),
        .shift_code (chg_shift),
        .steady     (steady)
    );

    // Gather the two test results for the counter.
    always_comb begin
        chk.fast   = fast;
        chk.steady = steady;
    end

    lock_rev_counter #(
        .P_REV_W (REV_W)
    ) u_rev (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .meas_valid (per_valid),
        .chk        (chk),
        .min_revs   (min_revs),
        .lock       (lock)
    );

    // Lock may rise only on a measurement faster than the limit (R2).
    p_rise_needs_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(fast));
endmodule

// File: tb/sim_spd_lock_det.sv
// Bench for spd_lock_det. A behavioural integer model runs beside the
// design and is compared on every clock; named scenario checks add
// hand-computed expectations for each requirement.
module sim_spd_lock_det;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        per_valid = 1'b0;
    logic [24:0] per_value = '0;
    logic [7:0]  minspd_lim = '0;
    logic [2:0]  chg_shift = '0;
    logic [7:0]  min_revs = '0;
    logic        lock;

    int n_checks = 0;
    int n_errors = 0;

    // behavioural model state
    longint m_lim = 0;
    longint m_prev = 0;
    bit     m_have = 0;
    int     m_cnt = 0;
    bit     m_lock = 0;

    spd_lock_det u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .per_valid  (per_valid),
        .per_value  (per_value),
        .minspd_lim (minspd_lim),
        .chg_shift  (chg_shift),
        .min_revs   (min_revs),
        .lock       (lock)
    );

    always #5 clk = ~clk;

    // model update at each rising edge
    always @(posedge clk) begin
        longint p, d, t;
        bit ok;
        if (!rst_n || !enable) begin
            m_have = 0;
            m_prev = 0;
            m_cnt  = min_revs;
            m_lock = 0;
        end else if (per_valid) begin
            p  = longint'(per_value);
            d  = (p >= m_prev) ? p - m_prev : m_prev - p;
            t  = p >> (chg_shift + 2);
            ok = (p < m_lim) && m_have && (d <= t);
            if (ok) begin
                if (m_cnt > 0) m_cnt = m_cnt - 1;
                m_lock = (m_cnt == 0);
            end else begin
                m_cnt  = min_revs;
                m_lock = 0;
            end
            m_prev = p;
            m_have = 1;
        end
        if (!rst_n) m_lim = 0;
        else        m_lim = longint'(minspd_lim) * 128000;
    end

    // compare against the model at every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if (lock !== m_lock) begin
                n_errors++;
                $display("FAIL model R5/R6 t=%0t lock=%0b expected=%0b", $time, lock, m_lock);
            end
        end
    end

    task automatic check(input string tag, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s lock=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // one strobe, then sample after the registered update
    task automatic strobe(input int p);
        @(negedge clk);
        per_value = 25'(p);
        per_valid = 1'b1;
        @(negedge clk);
        per_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        idle(3);
        check("R1 reset", lock, 1'b0);
        rst_n = 1'b1;
        minspd_lim = 8'd100;   // 12.8M cycles
        chg_shift  = 3'd1;     // /8
        min_revs   = 8'd3;
        idle(2);
        enable = 1'b1;
        idle(1);

        // R3 first period unstable, R5 three stable then lock
        strobe(1000000); check("R3 first", lock, 1'b0);
        strobe(1000000); check("R5 cnt2", lock, 1'b0);
        strobe(1000000); check("R5 cnt1", lock, 1'b0);
        strobe(1000000); check("R5 lock", lock, 1'b1);
        idle(5);          check("R7 hold", lock, 1'b1);
        strobe(1000000); check("R8 stay", lock, 1'b1);

        // R6 / R4 large change fails
        strobe(1200000); check("R6 fail", lock, 1'b0);

        // R4 boundaries with min_revs=0 so lock mirrors the pass
        min_revs = 8'd0;
        strobe(875000);  check("R4 setup", lock, 1'b0);
        strobe(1000000); check("R4 equal", lock, 1'b1);
        strobe(874999);  check("R4 over", lock, 1'b0);
        strobe(1000000); check("R4 over2", lock, 1'b0);
        strobe(1000000); check("R8 zero", lock, 1'b1);
        // R9 previous replaced by failing value
        strobe(5000000); check("R9 fail", lock, 1'b0);
        strobe(5100000); check("R9 prev", lock, 1'b1);

        // R4 code 7 (/512) and code 0 (/4)
        chg_shift = 3'd7;
        strobe(512000);  check("R4 k7 fail", lock, 1'b0);
        strobe(513000);  check("R4 k7 pass", lock, 1'b1);
        strobe(511000);  check("R4 k7 fail2", lock, 1'b0);
        chg_shift = 3'd0;
        strobe(600000);  check("R4 k0 pass", lock, 1'b1);

        // R2 limit boundary: 10 * 128000 = 1280000
        minspd_lim = 8'd10;
        strobe(1280000); check("R2 setup", lock, 1'b0);
        strobe(1280000); check("R2 equal", lock, 1'b0);
        strobe(1279999); check("R2 below", lock, 1'b1);
        minspd_lim = 8'd0;
        idle(1);
        strobe(1000);    check("R2 zero", lock, 1'b0);
        strobe(1000);    check("R2 zero2", lock, 1'b0);

        // same-cycle: counter at one with a min-speed failure
        minspd_lim = 8'd100;
        chg_shift  = 3'd1;
        min_revs   = 8'd2;
        strobe(1000000); check("R6 pre", lock, 1'b0);
        strobe(1000000); check("R5 cnt1b", lock, 1'b0);
        minspd_lim = 8'd5;   // 640000
        idle(1);
        strobe(1000000); check("R6 clash", lock, 1'b0);
        minspd_lim = 8'd100;
        idle(1);
        strobe(1000000); check("R6 reload", lock, 1'b0);
        strobe(1000000); check("R5 relock", lock, 1'b1);

        // enable drop together with a strobe
        @(negedge clk);
        per_value = 25'd1000000;
        per_valid = 1'b1;
        enable    = 1'b0;
        @(negedge clk);
        per_valid = 1'b0;
        check("R1 disable", lock, 1'b0);
        enable = 1'b1;
        idle(1);
        strobe(1000000); check("R3 re-enable", lock, 1'b0);
        strobe(1000000); check("R5 after", lock, 1'b0);
        strobe(1000000); check("R5 after2", lock, 1'b1);

        // reset mid-lock
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 rst", lock, 1'b0);
        idle(2);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule